// File: doc/BRIEF.md
# Two-Slot Edge Capture Unit

This unit watches an asynchronous input pin and, on the edges selected by an edge mode, copies the value of a free-running counter into one of two holding registers. The first qualifying edge fills the first register and the second fills the second. Once both are full, further edges are dropped until software clears the slot count, either by a clear pulse or by moving the edge mode from off to an active setting. A one-cycle event flag marks the capture selected by a count-select input: either the first or the second.

The pin passes through a two-flop synchroniser. An edge is recognised by comparing the synchronised level with the sample taken one cycle before. The counter itself and interrupt masking live outside this unit.

Top module: `dual_capture`

## Requirements
- R1: After reset both capture registers read zero and the event flag is low.
- R2: With edge mode 1 (rising), a low-to-high pin transition is captured and a high-to-low one is not.
- R3: With edge mode 2 (falling), a high-to-low pin transition is captured and a low-to-high one is not.
- R4: With edge mode 3 (both), every pin transition is captured.
- R5: With edge mode 0 (off), no transition changes either capture register.
- R6: While `dir_in` is 0 (pin not an input), no transition changes either capture register.
- R7: The first capture after the slot count is cleared goes to `cap_a`, the second goes to `cap_b`, and any later qualifying edge changes neither register.
- R8: `cap_evt` is high for exactly the cycle after the capture that `pair_sel` selects: the first capture when `pair_sel` is 0, the second when it is 1.
- R9: A `clr_slots` pulse resets the slot count, so the next qualifying edge is stored in `cap_a`.
- R10: A `mode_wr` strobe that moves the edge mode from 0 to a non-zero value resets the slot count. A strobe from one active mode to another does not.
- R11: A pin change applied before clock edge n stores the `count_val` sampled at edge n+2, after two synchroniser stages and one edge-compare stage.
- R12: When a clear is asserted in the same cycle as a qualifying edge, the clear wins and the edge is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_async | input | 1 | External pin, not synchronised |
| count_val | input | 32 | Current free-running counter value |
| edge_mode | input | 2 | 0 off, 1 rising, 2 falling, 3 both |
| pair_sel | input | 1 | 0: event on first capture, 1: event on second capture |
| dir_in | input | 1 | 1 when the pin is configured as an input |
| clr_slots | input | 1 | One-cycle pulse that resets the slot count |
| mode_wr | input | 1 | Strobe marking a write of `edge_mode` |
| cap_a | output | 32 | First capture register |
| cap_b | output | 32 | Second capture register |
| cap_evt | output | 1 | One-cycle capture event |

## Verification
The bench fills both slots and then keeps toggling the pin. A design that let the slot count wrap would overwrite `cap_a` with a third value. It switches between active modes without clearing and expects the slots to stay full, which catches a design that resets the count on every mode write. It also raises a clear in the exact cycle the synchronised edge appears, and expects no capture. A design that let the capture win would fill a slot the model believes is empty. Every stored value is compared against a counter two cycles after the pin change, so an extra or missing synchroniser stage shows up as an off-by-one value.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  // true when the prev->cur transition matches the selected mode
  function automatic logic edge_qualifies(edge_sel_e m, logic prev, logic cur);
    case (m)
      EDGE_RISE: return !prev && cur;
      EDGE_FALL: return prev && !cur;
      EDGE_ANY:  return prev != cur;
      default:   return 1'b0;
    endcase
  endfunction

  // mode write that arms the capture machinery from the off state
  function automatic logic arms_capture(edge_sel_e old_m, edge_sel_e new_m);
    return (old_m == EDGE_OFF) && (new_m != EDGE_OFF);
  endfunction
endpackage

// File: rtl/dcap_sync.sv
module dcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic cur,
  output logic prev
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      prev <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], d_async};
      prev <= sr[STAGES-1];
    end
  end

  assign cur = sr[STAGES-1];
endmodule

// File: rtl/dcap_slots.sv
module dcap_slots #(
  parameter int W     = 32,
  parameter int SLOTS = 2,
  localparam int CW   = $clog2(SLOTS + 1),
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take,
  input  logic                      clear,
  input  logic [SW-1:0]             sel,
  input  logic [W-1:0]              value,
  output logic [SLOTS-1:0][W-1:0]   caps,
  output logic [CW-1:0]             cnt,
  output logic                      evt
);
  logic room;
  logic store;

  assign room  = cnt < CW'(SLOTS);
  assign store = take && room && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      evt <= 1'b0;
    end else begin
      evt <= store && (cnt == CW'(sel));
      if (clear)      cnt <= '0;
      else if (store) cnt <= cnt + CW'(1);
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           slot_q <= '0;
      else if (store && cnt == CW'(i))      slot_q <= value;
    end
    assign caps[i] = slot_q;
  end
endmodule

// File: rtl/dual_capture.sv
module dual_capture
  import dcap_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_async,
  input  logic [W-1:0] count_val,
  input  logic [1:0]   edge_mode,
  input  logic         pair_sel,
  input  logic         dir_in,
  input  logic         clr_slots,
  input  logic         mode_wr,
  output logic [W-1:0] cap_a,
  output logic [W-1:0] cap_b,
  output logic         cap_evt
);
  localparam int SLOTS = 2;
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic                     pin_cur, pin_prev;
  logic                     take, arm, clear;
  edge_sel_e                mode_now, mode_q;
  logic [SLOTS-1:0][W-1:0]  caps;
  logic [CNT_W-1:0]         slot_cnt;

  dcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_async),
    .cur(pin_cur), .prev(pin_prev)
  );

  assign mode_now = edge_sel_e'(edge_mode);
  assign take     = dir_in && edge_qualifies(mode_now, pin_prev, pin_cur);
  assign arm      = mode_wr && arms_capture(mode_q, mode_now);
  assign clear    = clr_slots || arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= EDGE_OFF;
    else if (mode_wr) mode_q <= mode_now;
  end

  dcap_slots #(.W(W), .SLOTS(SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n), .take(take), .clear(clear),
    .sel(pair_sel), .value(count_val), .caps(caps),
    .cnt(slot_cnt), .evt(cap_evt)
  );

  assign cap_a = caps[0];
  assign cap_b = caps[1];
endmodule

// File: rtl/dual_capture_checker.sv
module dual_capture_checker #(
  parameter int W  = 32,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    edge_mode,
  input logic          dir_in,
  input logic          pair_sel,
  input logic          clr_slots,
  input logic [W-1:0]  cap_a,
  input logic [W-1:0]  cap_b,
  input logic          cap_evt,
  input logic [CW-1:0] slot_cnt
);
  p_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode == 2'd0) |=> ($stable(cap_a) && $stable(cap_b)));

  p_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_in |=> ($stable(cap_a) && $stable(cap_b)));

  p_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_cnt == CW'(2)) |=> ($stable(cap_a) && $stable(cap_b)));

  p_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_a) |-> (slot_cnt == CW'(1)));

  p_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_b) |-> (slot_cnt == CW'(2)));

  p_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (slot_cnt == ($past(pair_sel) ? CW'(2) : CW'(1))));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_slots |=> (slot_cnt == '0));
endmodule

bind dual_capture dual_capture_checker #(.W(W), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .dir_in(dir_in),
  .pair_sel(pair_sel), .clr_slots(clr_slots), .cap_a(cap_a), .cap_b(cap_b),
  .cap_evt(cap_evt), .slot_cnt(slot_cnt)
);

// File: tb/dual_capture_bench.sv
module dual_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_async = 1'b0;
  logic [31:0] count_val;
  logic [1:0]  edge_mode = 2'd0;
  logic        pair_sel = 1'b0;
  logic        dir_in = 1'b0;
  logic        clr_slots = 1'b0;
  logic        mode_wr = 1'b0;
  logic [31:0] cap_a, cap_b;
  logic        cap_evt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          slot;
    logic [31:0] val;
    logic        evt;
    string       tag;
  } exp_t;
  exp_t expq[$];

  // bench-side model state
  int   m_slots = 0;
  logic m_pin = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) count_val <= 32'd100;
    else        count_val <= count_val + 32'd1;

  dual_capture u_dual_capture (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .count_val(count_val),
    .edge_mode(edge_mode), .pair_sel(pair_sel), .dir_in(dir_in),
    .clr_slots(clr_slots), .mode_wr(mode_wr), .cap_a(cap_a), .cap_b(cap_b),
    .cap_evt(cap_evt)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit qual(logic [1:0] m, logic p, logic c);
    if (m == 2'd1) return (p == 1'b0) && (c == 1'b1);
    if (m == 2'd2) return (p == 1'b1) && (c == 1'b0);
    if (m == 2'd3) return p != c;
    return 1'b0;
  endfunction

  // driver: toggles pin and pushes the expected capture, if any
  task automatic drive_pin(logic lvl, string tag);
    logic [31:0] v;
    @(negedge clk);
    v = count_val;
    pin_async = lvl;
    if (dir_in && qual(edge_mode, m_pin, lvl) && m_slots < 2) begin
      expq.push_back('{m_slots, v + 32'd2, (m_slots == int'(pair_sel)), tag});
      m_slots++;
    end
    m_pin = lvl;
    repeat (5) @(negedge clk);
    check(expq.size() == 0, {tag, " pending"}, 32'(expq.size()), 32'd0);
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk);
    if (edge_mode == 2'd0 && m != 2'd0) m_slots = 0;
    edge_mode = m;
    mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic clear_pulse();
    @(negedge clk);
    clr_slots = 1'b1;
    m_slots = 0;
    @(negedge clk);
    clr_slots = 1'b0;
  endtask

  // monitor: compares every register change against the queue
  logic [31:0] last_a = '0, last_b = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      bit ca, cb;
      ca = (cap_a != last_a);
      cb = (cap_b != last_b);
      if (ca || cb || cap_evt) begin
        if (expq.size() == 0) begin
          check(0, "unexpected capture or event", ca ? cap_a : cap_b, 32'd0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (e.slot == 0)
            check(ca && !cb && cap_a == e.val, {e.tag, " cap_a"}, cap_a, e.val);
          else
            check(cb && !ca && cap_b == e.val, {e.tag, " cap_b"}, cap_b, e.val);
          check(cap_evt == e.evt, {e.tag, " cap_evt R8"}, 32'(cap_evt), 32'(e.evt));
        end
      end
      last_a = cap_a;
      last_b = cap_b;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cap_a == 0, "R1 cap_a reset", cap_a, 0);
    check(cap_b == 0, "R1 cap_b reset", cap_b, 0);
    check(cap_evt == 0, "R1 cap_evt reset", 32'(cap_evt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    dir_in = 1'b1;
    pair_sel = 1'b0;
    set_mode(2'd1);
    // R2 rising, R11 latency, R7 slot order and saturation
    drive_pin(1'b1, "R2 rise R11");
    drive_pin(1'b0, "R2 fall ignored");
    drive_pin(1'b1, "R7 second slot");
    drive_pin(1'b0, "R7 full");
    drive_pin(1'b1, "R7 full ignored");
    // R9 clear, then R3 falling (active->active switch keeps count)
    clear_pulse();
    set_mode(2'd2);
    drive_pin(1'b0, "R3 fall captured R9");
    drive_pin(1'b1, "R3 rise ignored");
    // R8 event on second capture
    pair_sel = 1'b1;
    clear_pulse();
    drive_pin(1'b0, "R8 first no evt");
    drive_pin(1'b1, "R8 rise ignored");
    drive_pin(1'b0, "R8 second evt");
    // R5 off mode
    set_mode(2'd0);
    clear_pulse();
    drive_pin(1'b1, "R5 off");
    drive_pin(1'b0, "R5 off");
    // R4 both edges, armed from off (R10)
    pair_sel = 1'b0;
    set_mode(2'd3);
    drive_pin(1'b1, "R4 any rise");
    drive_pin(1'b0, "R4 any fall");
    drive_pin(1'b1, "R4 full");
    // R10: active->active keeps full state, off->active rearms
    set_mode(2'd1);
    drive_pin(1'b0, "R10 no rearm");
    drive_pin(1'b1, "R10 no rearm");
    set_mode(2'd0);
    set_mode(2'd3);
    drive_pin(1'b0, "R10 rearmed");
    // R6 pin not an input
    clear_pulse();
    dir_in = 1'b0;
    drive_pin(1'b1, "R6 output dir");
    drive_pin(1'b0, "R6 output dir");
    dir_in = 1'b1;
    drive_pin(1'b1, "R6 input again");
    // R12 clear in the same cycle as the synchronised edge
    clear_pulse();
    @(negedge clk);
    pin_async = 1'b0;
    m_pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    clr_slots = 1'b1;
    m_slots = 0;
    @(negedge clk);
    clr_slots = 1'b0;
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R12 collide", 32'(expq.size()), 0);
    drive_pin(1'b1, "R12 after collide");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule